// File: doc/BRIEF.md
# Per-Port Statistics Counter Snapshot Reader

This block keeps a bank of per-port traffic statistics counters for up to six ports. Each port has 33 counters. A host reaches them through a 16-bit register port. Each cycle, every port may raise one event strobe. The strobe carries a counter index and an amount, and the amount is added to the selected counter, which saturates at its full width. Frame parsing that produces these events lies outside the block.

A host reads a counter in four steps:
1. It writes any word address of that counter. The write data is ignored.
2. The block copies the whole counter into a snapshot register of up to 64 bits in a single cycle.
3. The host polls the control register until the busy and clearing flags are low.
4. It fetches the snapshot in 16-bit words, most significant word first.

The same control register also starts a clear of every counter or of selected ports.

Top module: `port_stats_snapshot`

## Requirements
- R1: After reset, every counter is zero, the control register reads 0x0000 and the read data output is 0x0000.
- R2: Counters are placed in two address banks:
  - Counters 0 to 28 sit at 0x1000 + 0x40*port + offset. The offset is the sum of the word counts of the lower-numbered counters in that bank.
  - Counters 29 to 32 sit at 0x1180 + 8*port + 2*(index-29).
  - Counters 0, 1 and 20 span 4 words. All other counters span 2 words.
  - Within a counter, word n holds bits 16n+15 down to 16n, so the higher-order word sits at the higher address.
- R3: An event with a valid strobe adds its amount to counter index `ev_idx` of its port at the next clock edge. An index of 33 or above changes no counter.
- R4: A write to any word address of a counter captures that counter's value into the snapshot register. The captured value includes every event from earlier cycles and excludes the event in the write cycle. Later events leave the snapshot unchanged until the next capture, and the write data has no effect.
- R5: Reads are registered and return data in the cycle after the read strobe:
  - A word address of the counter last captured returns that snapshot word.
  - Any other counter address returns 0, and so does any address outside both banks and the control register.
  - A write to an address outside both banks and the control register changes nothing.
- R6: Control bit 0 (busy) reads 1 for the BUSY_CYCLES cycles after a capture write, then returns to 0.
- R7: Writing control bit 2 clears every counter. In the cycle after the write, the control register reads bits 1 and 2 as set. Events in the write cycle and in the next cycle are lost, and the flags drop on their own one cycle later.
- R8: Writing control bit (3+port) clears only that port's counters, with the same timing and flag behaviour as R7, and with bit 1 set in the cycle after the write.
- R9: A counter that would exceed its width holds at its all-ones value. The width is NARROW_W for 2-word counters and WIDE_W for 4-word counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| ev_valid_i | input | NUM_PORTS | Per-port event strobe |
| ev_idx_i | input | NUM_PORTS*6 | Per-port counter index, port p at bits 6p+5..6p |
| ev_amt_i | input | NUM_PORTS*AMT_W | Per-port increment amount |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 16 | Host word address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Registered host read data |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a capture write and an event on the counter being captured. The bench asserts both in the same cycle and requires the snapshot to exclude that increment. It keeps the event running through the busy wait and the word reads, and requires the read value to stay frozen. The second pair is a clear and incoming events. The bench drives events in the clear-write cycle and in the cycle after it on both cleared and untouched ports. It then requires zero on the cleared ports and exact sums on the others, with the expected values taken from its own saturating arithmetic model.

// File: rtl/port_stats_pkg.sv
package port_stats_pkg;

  localparam int NUM_CNT   = 33;
  localparam int BANK0_CNT = 29;
  localparam int IDX_W     = 6;
  localparam int PORT_W    = 3;

  localparam logic [15:0] BANK0_BASE   = 16'h1000;
  localparam logic [15:0] BANK0_STRIDE = 16'h0040;
  localparam logic [15:0] BANK1_BASE   = 16'h1180;
  localparam logic [15:0] BANK1_STRIDE = 16'h0008;
  localparam logic [15:0] CTRL_ADDR    = 16'h11F0;

  localparam int CTRL_BUSY  = 0;
  localparam int CTRL_RST   = 1;
  localparam int CTRL_ALL   = 2;
  localparam int CTRL_PORT0 = 3;

  // counters that span four words
  function automatic bit cnt_wide(int k);
    return (k == 0) || (k == 1) || (k == 20);
  endfunction

  function automatic int cnt_words(int k);
    return cnt_wide(k) ? 4 : 2;
  endfunction

  // word offset of counter k inside its bank
  function automatic int cnt_off(int k);
    int o;
    o = 0;
    if (k >= BANK0_CNT) begin
      o = 2 * (k - BANK0_CNT);
    end else begin
      for (int j = 0; j < k; j++) o = o + cnt_words(j);
    end
    return o;
  endfunction

  typedef struct packed {
    logic              hit;
    logic [PORT_W-1:0] port;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        word;
  } loc_t;

endpackage

// File: rtl/port_stats_addr_dec.sv
module port_stats_addr_dec
  import port_stats_pkg::*;
#(
  parameter int NUM_PORTS = 6
) (
  input  logic [15:0] addr_i,
  output loc_t        loc_o
);

  localparam logic [15:0] BANK0_END = BANK0_BASE + 16'(NUM_PORTS) * BANK0_STRIDE;
  localparam logic [15:0] BANK1_END = BANK1_BASE + 16'(NUM_PORTS) * BANK1_STRIDE;

  logic [15:0] rel0;
  logic [15:0] rel1;
  logic        in0;
  logic        in1;
  int          off;

  always_comb begin
    rel0  = addr_i - BANK0_BASE;
    rel1  = addr_i - BANK1_BASE;
    in0   = (addr_i >= BANK0_BASE) && (addr_i < BANK0_END);
    in1   = (addr_i >= BANK1_BASE) && (addr_i < BANK1_END);
    off   = 0;
    loc_o = '0;
    if (in0) begin
      off        = int'(rel0[5:0]);
      loc_o.port = rel0[6 +: PORT_W];
      for (int k = 0; k < BANK0_CNT; k++) begin
        if ((off >= cnt_off(k)) && (off < cnt_off(k) + cnt_words(k))) begin
          loc_o.hit  = 1'b1;
          loc_o.idx  = IDX_W'(k);
          loc_o.word = 2'(off - cnt_off(k));
        end
      end
    end else if (in1) begin
      off        = int'(rel1[2:0]);
      loc_o.port = rel1[3 +: PORT_W];
      for (int k = BANK0_CNT; k < NUM_CNT; k++) begin
        if ((off >= cnt_off(k)) && (off < cnt_off(k) + cnt_words(k))) begin
          loc_o.hit  = 1'b1;
          loc_o.idx  = IDX_W'(k);
          loc_o.word = 2'(off - cnt_off(k));
        end
      end
    end
  end

endmodule

// File: rtl/port_stats_cell.sv
module port_stats_cell #(
  parameter int W     = 32,
  parameter int AMT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     val_o
);

  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic [W:0]   sum;
  logic         val_en;

  always_comb begin
    sum    = {1'b0, val_q} + (W+1)'(amt_i);
    val_en = clr_i | inc_i;
    if (clr_i) begin
      val_d = '0;
    end else if (sum[W]) begin
      val_d = '1;
    end else begin
      val_d = sum[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  assign val_o = val_q;

endmodule

// File: rtl/port_stats_ctrl.sv
module port_stats_ctrl
  import port_stats_pkg::*;
#(
  parameter int NUM_PORTS   = 6,
  parameter int BUSY_CYCLES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 latch_i,
  input  logic                 ctrl_wr_i,
  input  logic [15:0]          wdata_i,
  output logic                 busy_o,
  output logic                 pend_all_o,
  output logic [NUM_PORTS-1:0] pend_port_o
);

  localparam int BCW = $clog2(BUSY_CYCLES + 1);

  logic [BCW-1:0]       bcnt_q;
  logic [BCW-1:0]       bcnt_d;
  logic                 bcnt_en;
  logic                 pend_all_q;
  logic                 pend_all_d;
  logic [NUM_PORTS-1:0] pend_port_q;
  logic [NUM_PORTS-1:0] pend_port_d;
  logic                 pend_en;

  always_comb begin
    bcnt_en     = latch_i || (bcnt_q != '0);
    bcnt_d      = latch_i ? BCW'(BUSY_CYCLES) : (bcnt_q - BCW'(1));
    pend_en     = ctrl_wr_i || pend_all_q || (|pend_port_q);
    pend_all_d  = ctrl_wr_i && wdata_i[CTRL_ALL];
    pend_port_d = ctrl_wr_i ? wdata_i[CTRL_PORT0 +: NUM_PORTS] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
    end else if (bcnt_en) begin
      bcnt_q <= bcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_all_q  <= 1'b0;
      pend_port_q <= '0;
    end else if (pend_en) begin
      pend_all_q  <= pend_all_d;
      pend_port_q <= pend_port_d;
    end
  end

  assign busy_o      = (bcnt_q != '0);
  assign pend_all_o  = pend_all_q;
  assign pend_port_o = pend_port_q;

endmodule

// File: rtl/port_stats_snapshot.sv
module port_stats_snapshot
  import port_stats_pkg::*;
#(
  parameter int NUM_PORTS   = 6,
  parameter int NARROW_W    = 32,
  parameter int WIDE_W      = 64,
  parameter int AMT_W       = 16,
  parameter int BUSY_CYCLES = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS-1:0]       ev_valid_i,
  input  logic [NUM_PORTS*IDX_W-1:0] ev_idx_i,
  input  logic [NUM_PORTS*AMT_W-1:0] ev_amt_i,
  input  logic                       host_wr_i,
  input  logic                       host_rd_i,
  input  logic [15:0]                host_addr_i,
  input  logic [15:0]                host_wdata_i,
  output logic [15:0]                host_rdata_o
);

  loc_t                 loc;
  logic                 is_ctrl;
  logic                 latch;
  logic                 ctrl_wr;
  logic                 busy;
  logic                 pend_all;
  logic                 resetting;
  logic [NUM_PORTS-1:0] pend_port;
  logic [NUM_PORTS-1:0] port_clr;
  logic [63:0]          cnt_val [NUM_PORTS][NUM_CNT];
  logic [63:0]          sel_val;

  logic [63:0]          snap_q;
  logic [PORT_W-1:0]    snap_port_q;
  logic [IDX_W-1:0]     snap_idx_q;
  logic                 snap_vld_q;
  logic                 snap_en;

  logic [15:0]          ctrl_word;
  logic                 snap_match;
  logic [15:0]          rdata_q;
  logic [15:0]          rdata_d;
  logic                 rdata_en;

  port_stats_addr_dec #(.NUM_PORTS(NUM_PORTS)) u_dec (
    .addr_i (host_addr_i),
    .loc_o  (loc)
  );

  assign is_ctrl = (host_addr_i == CTRL_ADDR);
  assign latch   = host_wr_i && loc.hit;
  assign ctrl_wr = host_wr_i && is_ctrl;

  port_stats_ctrl #(
    .NUM_PORTS   (NUM_PORTS),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_i     (latch),
    .ctrl_wr_i   (ctrl_wr),
    .wdata_i     (host_wdata_i),
    .busy_o      (busy),
    .pend_all_o  (pend_all),
    .pend_port_o (pend_port)
  );

  assign resetting = pend_all | (|pend_port);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_clr[p] = pend_all | pend_port[p];
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      logic inc;
      assign inc = ev_valid_i[p] && (ev_idx_i[p*IDX_W +: IDX_W] == IDX_W'(k));
      if (cnt_wide(k)) begin : g_wide
        logic [WIDE_W-1:0] v;
        port_stats_cell #(.W(WIDE_W), .AMT_W(AMT_W)) u_cell (
          .clk   (clk),
          .rst_n (rst_n),
          .clr_i (port_clr[p]),
          .inc_i (inc),
          .amt_i (ev_amt_i[p*AMT_W +: AMT_W]),
          .val_o (v)
        );
        assign cnt_val[p][k] = 64'(v);
      end else begin : g_narrow
        logic [NARROW_W-1:0] v;
        port_stats_cell #(.W(NARROW_W), .AMT_W(AMT_W)) u_cell (
          .clk   (clk),
          .rst_n (rst_n),
          .clr_i (port_clr[p]),
          .inc_i (inc),
          .amt_i (ev_amt_i[p*AMT_W +: AMT_W]),
          .val_o (v)
        );
        assign cnt_val[p][k] = 64'(v);
      end
    end
  end

  // counter selection for capture
  always_comb begin
    sel_val = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int k = 0; k < NUM_CNT; k++) begin
        if ((loc.port == PORT_W'(p)) && (loc.idx == IDX_W'(k))) sel_val = cnt_val[p][k];
      end
    end
  end

  assign snap_en = latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q      <= '0;
      snap_port_q <= '0;
      snap_idx_q  <= '0;
      snap_vld_q  <= 1'b0;
    end else if (snap_en) begin
      snap_q      <= sel_val;
      snap_port_q <= loc.port;
      snap_idx_q  <= loc.idx;
      snap_vld_q  <= 1'b1;
    end
  end

  // read path
  always_comb begin
    ctrl_word            = '0;
    ctrl_word[CTRL_BUSY] = busy;
    ctrl_word[CTRL_RST]  = resetting;
    ctrl_word[CTRL_ALL]  = pend_all;
    for (int p = 0; p < NUM_PORTS; p++) ctrl_word[CTRL_PORT0 + p] = pend_port[p];

    snap_match = snap_vld_q && loc.hit && (loc.port == snap_port_q) && (loc.idx == snap_idx_q);
    rdata_en   = host_rd_i;
    if (is_ctrl) begin
      rdata_d = ctrl_word;
    end else if (snap_match) begin
      rdata_d = snap_q[{loc.word, 4'b0000} +: 16];
    end else begin
      rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign host_rdata_o = rdata_q;

endmodule

// File: rtl/port_stats_snapshot_chk.sv
module port_stats_snapshot_chk
  import port_stats_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr_i,
  input logic        host_rd_i,
  input logic [15:0] host_addr_i,
  input logic [15:0] host_wdata_i,
  input logic [15:0] host_rdata_o,
  input logic        latch,
  input logic        busy,
  input logic        resetting,
  input logic [63:0] snap_q
);

  logic ctrl_w;
  assign ctrl_w = host_wr_i && (host_addr_i == CTRL_ADDR);

  AST_LATCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> busy); // R6

  AST_GLOBAL_CLEAR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_w && host_wdata_i[CTRL_ALL]) |=> resetting); // R7

  AST_PORT_CLEAR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_w && host_wdata_i[CTRL_PORT0]) |=> resetting); // R8

  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (resetting && !ctrl_w) |=> !resetting); // R7

  AST_SNAPSHOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(snap_q)); // R4

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd_i |=> $stable(host_rdata_o)); // R5

  AST_LOW_ADDR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_i && (host_addr_i < BANK0_BASE)) |=> (host_rdata_o == 16'h0000)); // R5

endmodule

bind port_stats_snapshot port_stats_snapshot_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr_i    (host_wr_i),
  .host_rd_i    (host_rd_i),
  .host_addr_i  (host_addr_i),
  .host_wdata_i (host_wdata_i),
  .host_rdata_o (host_rdata_o),
  .latch        (latch),
  .busy         (busy),
  .resetting    (resetting),
  .snap_q       (snap_q)
);

// File: tb/test_port_stats_snapshot.sv
module test_port_stats_snapshot;

  localparam int NP = 6;
  localparam int NC = 33;
  localparam int NW = 18;
  localparam int WW = 40;
  localparam int AW = 16;
  localparam int BC = 3;
  localparam logic [15:0] CTRL = 16'h11F0;

  logic             clk;
  logic             rst_n;
  logic [NP-1:0]    ev_valid;
  logic [NP*6-1:0]  ev_idx;
  logic [NP*AW-1:0] ev_amt;
  logic             host_wr;
  logic             host_rd;
  logic [15:0]      host_addr;
  logic [15:0]      host_wdata;
  logic [15:0]      host_rdata;

  longint model [NP][NC];
  int     n_chk;
  int     n_fail;
  bit     done;

  port_stats_snapshot #(
    .NUM_PORTS(NP), .NARROW_W(NW), .WIDE_W(WW), .AMT_W(AW), .BUSY_CYCLES(BC)
  ) i_port_stats_snapshot (
    .clk(clk), .rst_n(rst_n),
    .ev_valid_i(ev_valid), .ev_idx_i(ev_idx), .ev_amt_i(ev_amt),
    .host_wr_i(host_wr), .host_rd_i(host_rd), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // layout as stated in R2
  function automatic bit is_wide(int k);
    return (k == 0) || (k == 1) || (k == 20);
  endfunction
  function automatic int wlen(int k);
    return is_wide(k) ? 4 : 2;
  endfunction
  function automatic int base_addr(int p, int k);
    int o;
    o = 0;
    if (k >= 29) return 'h1180 + 8 * p + 2 * (k - 29);
    for (int j = 0; j < k; j++) o = o + wlen(j);
    return 'h1000 + 'h40 * p + o;
  endfunction
  function automatic longint satmax(int k);
    return (longint'(1) << (is_wide(k) ? WW : NW)) - 1;
  endfunction

  task automatic add(int p, int k, int amt);
    longint m;
    if (k < NC) begin
      m = model[p][k] + longint'(amt);
      if (m > satmax(k)) m = satmax(k);
      model[p][k] = m;
    end
  endtask

  task automatic set_ev(int p, int k, int amt, bit apply);
    ev_valid[p]         = 1'b1;
    ev_idx[p*6 +: 6]    = 6'(k);
    ev_amt[p*AW +: AW]  = 16'(amt);
    if (apply) add(p, k, amt);
  endtask

  task automatic clr_ev();
    ev_valid = '0;
    ev_idx   = '0;
    ev_amt   = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_write(int a, int d);
    host_wr    = 1'b1;
    host_addr  = 16'(a);
    host_wdata = 16'(d);
    step();
    host_wr    = 1'b0;
  endtask

  task automatic host_read(int a, output logic [15:0] d);
    host_rd   = 1'b1;
    host_addr = 16'(a);
    step();
    host_rd   = 1'b0;
    d         = host_rdata;
  endtask

  task automatic read_cnt(int p, int k, output longint v);
    logic [15:0] d;
    host_write(base_addr(p, k) + (p % wlen(k)), 16'hBEEF);
    repeat (BC) step();
    v = 0;
    for (int i = wlen(k) - 1; i >= 0; i--) begin
      host_read(base_addr(p, k) + i, d);
      v = (v << 16) | longint'(d);
    end
  endtask

  task automatic verify_cnt(int p, int k, string req);
    longint v;
    read_cnt(p, k, v);
    chk(req, v, model[p][k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    longint      v;
    longint      snap_exp;
    n_chk = 0; n_fail = 0; done = 1'b0;
    host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    clr_ev();
    for (int p = 0; p < NP; p++) for (int k = 0; k < NC; k++) model[p][k] = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 rdata", longint'(host_rdata), 0);
    host_read(CTRL, d);
    chk("R1 ctrl", longint'(d), 0);
    verify_cnt(3, 7, "R1 counter");

    // R3: mixed events, including invalid indices 33 and 34
    for (int t = 0; t < 40; t++) begin
      for (int p = 0; p < NP; p++) begin
        int k;
        k = (p * 7 + t * 5 + 3) % 35;
        set_ev(p, k, (p * 131 + t * 977 + k * 13 + 1) % 65536, 1'b1);
      end
      step();
      clr_ev();
    end
    // R2 / R3: full sweep of every counter of every port
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < NC; k++) verify_cnt(p, k, "R2 R3 sweep");

    // R6: busy window after a capture write
    host_write(base_addr(1, 20), 0);
    host_read(CTRL, d);
    chk("R6 busy first", longint'(d[0]), 1);
    step();
    host_read(CTRL, d);
    chk("R6 busy last", longint'(d[0]), 1);
    host_read(CTRL, d);
    chk("R6 busy done", longint'(d[0]), 0);

    // R4: capture coincides with an event on the same counter
    set_ev(4, 0, 16'h1234, 1'b0);
    snap_exp = model[4][0];
    host_write(base_addr(4, 0), 16'hBEEF);
    add(4, 0, 16'h1234);
    set_ev(4, 0, 16'h0F0F, 1'b0);
    repeat (BC) begin add(4, 0, 16'h0F0F); step(); end
    v = 0;
    for (int i = 3; i >= 0; i--) begin
      add(4, 0, 16'h0F0F);
      host_read(base_addr(4, 0) + i, d);
      v = (v << 16) | longint'(d);
    end
    clr_ev();
    chk("R4 snapshot frozen", v, snap_exp);
    verify_cnt(4, 0, "R4 recapture");

    // R5: non-latched and unmapped reads, unmapped writes
    host_read(base_addr(4, 1), d);
    chk("R5 other counter", longint'(d), 0);
    host_read(16'h0000, d);
    chk("R5 low addr", longint'(d), 0);
    host_read(16'h11B0, d);
    chk("R5 gap addr", longint'(d), 0);
    host_write(16'h0005, 16'hFFFF);
    host_read(CTRL, d);
    chk("R5 unmapped write ctrl", longint'(d), 0);
    host_read(base_addr(4, 0), d);
    chk("R5 unmapped write snapshot", longint'(d), model[4][0] & 64'hFFFF);

    // R9: narrow saturation
    for (int i = 0; i < 5; i++) begin set_ev(2, 5, 16'hFFFF, 1'b1); step(); clr_ev(); end
    verify_cnt(2, 5, "R9 saturate");
    chk("R9 model max", model[2][5], (longint'(1) << NW) - 1);
    set_ev(2, 5, 16'h0001, 1'b1); step(); clr_ev();
    verify_cnt(2, 5, "R9 hold");

    // R7: global clear with events in the write cycle and the cycle after
    set_ev(0, 3, 50, 1'b0);
    host_write(CTRL, 16'h0004);
    clr_ev();
    set_ev(1, 3, 5, 1'b0);
    host_read(CTRL, d);
    clr_ev();
    chk("R7 flags", longint'(d), 16'h0006);
    for (int p = 0; p < NP; p++) for (int k = 0; k < NC; k++) model[p][k] = 0;
    set_ev(2, 3, 7, 1'b1);
    host_read(CTRL, d);
    clr_ev();
    chk("R7 flags drop", longint'(d), 0);
    verify_cnt(0, 3, "R7 write-cycle event");
    verify_cnt(1, 3, "R7 next-cycle event");
    verify_cnt(2, 3, "R7 after clear");
    verify_cnt(5, 32, "R7 zero");
    verify_cnt(3, 0, "R7 zero wide");

    // R8: per-port clear
    for (int t = 0; t < 3; t++) begin
      for (int p = 0; p < NP; p++) set_ev(p, 10, 100, 1'b1);
      step();
      clr_ev();
    end
    host_write(CTRL, 16'h0080);
    set_ev(4, 10, 9, 1'b0);
    set_ev(3, 10, 9, 1'b1);
    host_read(CTRL, d);
    clr_ev();
    chk("R8 flags", longint'(d), 16'h0082);
    for (int k = 0; k < NC; k++) model[4][k] = 0;
    verify_cnt(4, 10, "R8 cleared port");
    verify_cnt(3, 10, "R8 neighbour");
    verify_cnt(2, 10, "R8 untouched");
    host_write(CTRL, 16'h0108);
    step();
    for (int k = 0; k < NC; k++) begin model[0][k] = 0; model[5][k] = 0; end
    verify_cnt(0, 10, "R8 port0");
    verify_cnt(5, 10, "R8 port5");
    verify_cnt(1, 10, "R8 port1 kept");

    // R2: four-word counters above 32 bits
    for (int i = 0; i < 65540; i++) begin
      set_ev(0, 0, 16'hFFFF, 1'b1);
      set_ev(1, 20, 16'hFFFF, 1'b1);
      set_ev(5, 1, 16'hFFFF, 1'b1);
      step();
    end
    clr_ev();
    verify_cnt(0, 0, "R2 wide word order");
    verify_cnt(1, 20, "R2 wide word order");
    verify_cnt(5, 1, "R2 wide word order");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule